// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Receiver

This block sits behind an E1 framer that has already found frame and multiframe alignment. It takes the received serial stream one bit per enabled clock, along with strobes that mark the first bit of each frame and the first bit of each 16-frame signaling multiframe. From every frame it keeps the byte carried in timeslot 16. Across a multiframe these sixteen bytes hold the four signaling bits (A, B, C, D) of all 30 voice channels. Frame 0 instead carries the multiframe alignment nibble, spare bits and the remote-alarm bit Y.

The bytes are collected into a shadow buffer. They are copied into sixteen readable signaling registers in a single clock when the last bit of frame 15 arrives. Software therefore always sees one coherent multiframe and has one full multiframe, 2 ms, to read it. The copy sets a sticky interrupt flag, and reading the second status register clears that flag. The Y bit is filtered across multiframes and reported as a remote-alarm status bit.

Register at address 0x30+f holds the byte of frame f. For f from 1 to 15, its upper nibble is A..D of channel f and its lower nibble is A..D of channel f+15.

Top module: `e1_sig_extract`

## Requirements
- R1: After reset, every signaling register reads 0x00, `mf_irq_o` is 0 and `rai_o` is 0.
- R2: Timeslot-16 bits arrive most significant bit first. Timeslot 16 occupies frame bit positions 128 to 135, counted from 0 at the frame strobe. After a multiframe has been committed, the register at address 0x30+f (f = 1..15) reads the timeslot-16 byte of frame f of that multiframe.
- R3: Address 0x30 reads bits 7..4 as 0. Its bits 3..0 are bits 3..0 of the frame-0 timeslot-16 byte, and bit 2 of that byte is the Y bit.
- R4: The registers change only in the clock after the last bit (bit 255) of frame 15 is accepted, and all of them change together. A read in the middle of a multiframe returns the previous multiframe's values.
- R5: No commit and no interrupt happen until a multiframe strobe has been accepted since reset.
- R6: A commit sets `mf_irq_o` in the next clock, and the flag stays set until cleared. It reads as bit 7 of status register 2 at address 0x07.
- R7: A read of address 0x07 clears the flag. If a commit happens in the same clock as the read, the flag stays set, and that read returns the flag's old value.
- R8: `rai_o`, also bit 6 of status register 1 at address 0x06, goes to 1 after two consecutive committed multiframes with Y=1. It goes to 0 after two consecutive committed multiframes with Y=0. It changes only on a commit.
- R9: Read data appears on `rd_data_o` in the clock after `rd_en_i`, holds while `rd_en_i` is low, and is 0x00 for addresses outside 0x06, 0x07 and 0x30..0x3F.
- R10: In a clock with `bit_en_i` low, the serial bit and both sync strobes are ignored, and bit and frame positions do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | A serial bit is presented this clock |
| rx_bit_i | input | 1 | Received serial data bit |
| frame_sync_i | input | 1 | Current bit is bit 0 of a frame |
| mf_sync_i | input | 1 | Current bit is bit 0 of frame 0 of a multiframe |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Registered read data |
| mf_irq_o | output | 1 | Sticky multiframe-ready flag |
| rai_o | output | 1 | Integrated remote-alarm status |

## Verification
The assertions assume that the sync strobes are only meaningful together with `bit_en_i`. They also assume that a multiframe strobe always comes together with a frame strobe, and that a commit is the only event that can move the registers or the alarm bit. The stimulus drives fully aligned multiframes, with both strobes set on the first bit of frame 0 and the frame strobe set on every frame. It puts an idle clock with a contradicting bit and spurious strobes after every accepted bit. Reads are issued only between bits, except for one read that is deliberately placed on the clock that accepts the final bit of a multiframe.

// File: rtl/e1_sig_pkg.sv
package e1_sig_pkg;
  localparam int TS_BITS    = 8;
  localparam int FRAME_TS   = 32;
  localparam int MF_FRAMES  = 16;
  localparam int SIG_SLOT   = 16;
  localparam int ADDR_W     = 8;
  localparam int SIG_BASE   = 'h30;
  localparam int STAT1_ADDR = 'h06;
  localparam int STAT2_ADDR = 'h07;
  localparam int Y_POS      = 2;
  localparam int RAI_BIT    = 6;
  localparam int IRQ_BIT    = 7;
  localparam int FW         = $clog2(MF_FRAMES);
endpackage

// File: rtl/e1_ts16_capture.sv
module e1_ts16_capture
  import e1_sig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               rx_bit_i,
  input  logic               frame_sync_i,
  input  logic               mf_sync_i,
  output logic               byte_we_o,
  output logic [FW-1:0]      byte_idx_o,
  output logic [TS_BITS-1:0] byte_o,
  output logic               mf_end_o
);
  localparam int FRAME_BITS = TS_BITS * FRAME_TS;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int SLOT_LAST  = SIG_SLOT * TS_BITS + TS_BITS - 1;

  logic [BW-1:0]      bit_cnt_q, cur_bit;
  logic [FW-1:0]      frm_cnt_q, cur_frm;
  logic [TS_BITS-1:0] sh_q;
  logic               mf_seen_q;
  logic               frame_last;

  assign cur_bit    = frame_sync_i ? '0 : bit_cnt_q;
  assign cur_frm    = mf_sync_i ? '0 : frm_cnt_q;
  assign frame_last = cur_bit == BW'(FRAME_BITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      frm_cnt_q <= '0;
      sh_q      <= '0;
      mf_seen_q <= 1'b0;
    end else if (bit_en_i) begin
      sh_q <= {sh_q[TS_BITS-2:0], rx_bit_i};
      if (mf_sync_i) mf_seen_q <= 1'b1;
      if (frame_last) begin
        bit_cnt_q <= '0;
        frm_cnt_q <= (cur_frm == FW'(MF_FRAMES - 1)) ? '0 : cur_frm + 1'b1;
      end else begin
        bit_cnt_q <= cur_bit + 1'b1;
        frm_cnt_q <= cur_frm;
      end
    end
  end

  assign byte_o     = {sh_q[TS_BITS-2:0], rx_bit_i};
  assign byte_idx_o = cur_frm;
  assign byte_we_o  = bit_en_i && (cur_bit == BW'(SLOT_LAST));
  // commit only once alignment has been seen
  assign mf_end_o   = bit_en_i && frame_last && (cur_frm == FW'(MF_FRAMES - 1))
                      && (mf_seen_q || mf_sync_i);
endmodule

// File: rtl/e1_sig_store.sv
module e1_sig_store
  import e1_sig_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         byte_we_i,
  input  logic [FW-1:0]                byte_idx_i,
  input  logic [TS_BITS-1:0]           byte_i,
  input  logic                         commit_i,
  output logic [MF_FRAMES*TS_BITS-1:0] live_o,
  output logic                         y_o
);
  logic [MF_FRAMES*TS_BITS-1:0] shadow;

  for (genvar i = 0; i < MF_FRAMES; i++) begin : g_reg
    logic [TS_BITS-1:0] sh_q, lv_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
        lv_q <= '0;
      end else begin
        if (byte_we_i && byte_idx_i == FW'(i)) sh_q <= byte_i;
        if (commit_i) lv_q <= sh_q;
      end
    end
    assign shadow[i*TS_BITS +: TS_BITS] = sh_q;
    assign live_o[i*TS_BITS +: TS_BITS] = lv_q;
  end

  assign y_o = shadow[Y_POS];
endmodule

// File: rtl/e1_rai_integ.sv
module e1_rai_integ (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic y_i,
  output logic rai_o
);
  logic hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 1'b0;
      rai_o  <= 1'b0;
    end else if (commit_i) begin
      hist_q <= y_i;
      if (y_i && hist_q)        rai_o <= 1'b1;
      else if (!y_i && !hist_q) rai_o <= 1'b0;
    end
  end
endmodule

// File: rtl/e1_sig_regport.sv
module e1_sig_regport
  import e1_sig_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  input  logic [MF_FRAMES*TS_BITS-1:0] live_i,
  input  logic                         commit_i,
  input  logic                         rai_i,
  output logic [TS_BITS-1:0]           rd_data_o,
  output logic                         irq_o
);
  localparam logic [TS_BITS-1:0] LOW_MASK = {{(TS_BITS/2){1'b0}}, {(TS_BITS/2){1'b1}}};

  logic [TS_BITS-1:0] rd_mux;
  logic               stat2_rd;

  assign stat2_rd = rd_en_i && (rd_addr_i == ADDR_W'(STAT2_ADDR));

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == ADDR_W'(STAT1_ADDR)) rd_mux[RAI_BIT] = rai_i;
    if (rd_addr_i == ADDR_W'(STAT2_ADDR)) rd_mux[IRQ_BIT] = irq_o;
    for (int i = 0; i < MF_FRAMES; i++) begin
      if (rd_addr_i == ADDR_W'(SIG_BASE + i))
        rd_mux = (i == 0) ? (live_i[i*TS_BITS +: TS_BITS] & LOW_MASK)
                          : live_i[i*TS_BITS +: TS_BITS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_mux;
      if (commit_i)      irq_o <= 1'b1;   // set wins over clear
      else if (stat2_rd) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/e1_sig_extract.sv
module e1_sig_extract
  import e1_sig_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_en_i,
  input  logic                rx_bit_i,
  input  logic                frame_sync_i,
  input  logic                mf_sync_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [TS_BITS-1:0]  rd_data_o,
  output logic                mf_irq_o,
  output logic                rai_o
);
  logic                         byte_we_w, mf_end_w, y_w;
  logic [FW-1:0]                byte_idx_w;
  logic [TS_BITS-1:0]           byte_w;
  logic [MF_FRAMES*TS_BITS-1:0] live_w;

  e1_ts16_capture i_capture (
    .clk_i, .rst_ni, .bit_en_i, .rx_bit_i, .frame_sync_i, .mf_sync_i,
    .byte_we_o(byte_we_w), .byte_idx_o(byte_idx_w), .byte_o(byte_w), .mf_end_o(mf_end_w)
  );

  e1_sig_store i_store (
    .clk_i, .rst_ni, .byte_we_i(byte_we_w), .byte_idx_i(byte_idx_w), .byte_i(byte_w),
    .commit_i(mf_end_w), .live_o(live_w), .y_o(y_w)
  );

  e1_rai_integ i_rai (
    .clk_i, .rst_ni, .commit_i(mf_end_w), .y_i(y_w), .rai_o(rai_o)
  );

  e1_sig_regport i_regport (
    .clk_i, .rst_ni, .rd_en_i, .rd_addr_i, .live_i(live_w), .commit_i(mf_end_w),
    .rai_i(rai_o), .rd_data_o, .irq_o(mf_irq_o)
  );
endmodule

// File: rtl/e1_sig_extract_chk.sv
module e1_sig_extract_chk
  import e1_sig_pkg::*;
(
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         rd_en_i,
  input logic [ADDR_W-1:0]            rd_addr_i,
  input logic [TS_BITS-1:0]           rd_data_o,
  input logic                         mf_irq_o,
  input logic                         rai_o,
  input logic                         commit_i,
  input logic [MF_FRAMES*TS_BITS-1:0] live_i
);
  AST_REG0_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == ADDR_W'(SIG_BASE) |=> rd_data_o[TS_BITS-1:TS_BITS/2] == '0); // R3
  AST_LIVE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(live_i)); // R4
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> mf_irq_o); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_irq_o && !(rd_en_i && rd_addr_i == ADDR_W'(STAT2_ADDR)) |=> mf_irq_o); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == ADDR_W'(STAT2_ADDR) && !commit_i |=> !mf_irq_o); // R7
  AST_RAI_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(rai_o)); // R8
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R9
  AST_RD_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i >= ADDR_W'(SIG_BASE + MF_FRAMES) |=> rd_data_o == '0); // R9
endmodule

bind e1_sig_extract e1_sig_extract_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o), .mf_irq_o(mf_irq_o), .rai_o(rai_o),
  .commit_i(mf_end_w), .live_i(live_w)
);

// File: tb/test_e1_sig_extract.sv
`timescale 1ns/1ps
module test_e1_sig_extract;
  logic       clk = 0, rst_ni = 0;
  logic       bit_en = 0, rx_bit = 0, fsync = 0, msync = 0, rd_en = 0;
  logic [7:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       mf_irq, rai;
  int         checks = 0, errors = 0;
  bit         done = 0;
  logic [7:0] exp_reg [16];

  always #4 clk = ~clk;

  e1_sig_extract i_e1_sig_extract (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .rx_bit_i(rx_bit),
    .frame_sync_i(fsync), .mf_sync_i(msync), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .mf_irq_o(mf_irq), .rai_o(rai)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ts16_byte(int seed, int f, bit y);
    logic [7:0] s = 8'(seed);
    if (f == 0) return {s[7:4] | 4'h1, s[0], y, s[1], s[2]};
    return 8'(seed * 7 + f * 29 + 3);
  endfunction

  // accepted bit followed by an idle clock carrying garbage (R10)
  task automatic send_bit(bit b, bit fs, bit ms, bit rd);
    bit_en = 1; rx_bit = b; fsync = fs; msync = ms;
    if (rd) begin rd_en = 1; rd_addr = 8'h07; end
    @(posedge clk); @(negedge clk);
    bit_en = 0; rx_bit = ~b; fsync = 1; msync = 1; rd_en = 0;
    @(posedge clk); @(negedge clk);
    fsync = 0; msync = 0;
  endtask

  task automatic send_frames(int seed, bit y, int f_lo, int f_hi, bit sync, bit rd_last);
    for (int f = f_lo; f <= f_hi; f++) begin
      logic [7:0] by = ts16_byte(seed, f, y);
      for (int b = 0; b < 256; b++) begin
        bit v = (b >= 128 && b < 136) ? by[7 - (b - 128)] : 1'(((b * 5 + f * 3 + seed) >> 1) & 1);
        send_bit(v, sync && b == 0, sync && b == 0 && f == 0, rd_last && f == 15 && b == 255);
      end
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data; rd_en = 0;
  endtask

  task automatic set_exp(int seed, bit y);
    for (int f = 0; f < 16; f++) exp_reg[f] = ts16_byte(seed, f, y);
    exp_reg[0][7:4] = 4'h0;
  endtask

  task automatic sweep(string req);
    logic [7:0] d;
    for (int k = 0; k < 16; k++) begin
      rd(8'(8'h30 + k), d);
      check(req, d, exp_reg[k]);
    end
  endtask

  task automatic mf(int seed, bit y, int exp_rai);
    logic [7:0] d;
    send_frames(seed, y, 0, 15, 1, 0);
    set_exp(seed, y);
    sweep("R2 R3 R10 register sweep");
    check("R8 rai_o", rai, exp_rai);
    rd(8'h06, d);
    check("R8 status1", d, exp_rai ? 8'h40 : 8'h00);
    rd(8'h07, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, held;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 irq after reset", mf_irq, 0);
    check("R1 rai after reset", rai, 0);
    for (int k = 0; k < 16; k++) exp_reg[k] = 8'h00;
    sweep("R1 registers after reset");

    // no sync yet: nothing commits
    send_frames(8'h5A, 1, 0, 15, 0, 0);
    check("R5 irq before sync", mf_irq, 0);
    sweep("R5 registers before sync");

    // multiframe A
    send_frames(11, 1, 0, 15, 1, 0);
    check("R6 irq after commit", mf_irq, 1);
    rd(8'h07, d);
    check("R6 status2 flag", d, 8'h80);
    check("R7 irq cleared by read", mf_irq, 0);
    rd(8'h07, d);
    check("R7 status2 after clear", d, 8'h00);
    set_exp(11, 1);
    sweep("R2 R3 multiframe A");
    check("R8 rai after one Y=1", rai, 0);

    // multiframe B, read in the middle
    send_frames(99, 1, 0, 7, 1, 0);
    sweep("R4 mid-multiframe keeps old values");
    check("R4 no irq mid-multiframe", mf_irq, 0);
    send_frames(99, 1, 8, 15, 1, 0);
    set_exp(99, 1);
    sweep("R4 R2 multiframe B");
    check("R8 rai after two Y=1", rai, 1);
    rd(8'h06, d);
    check("R8 status1 set", d, 8'h40);
    rd(8'h07, d);

    // multiframe C with status2 read on the commit clock
    send_frames(200, 0, 0, 15, 1, 1);
    check("R7 read data old flag", rd_data, 8'h00);
    check("R7 set wins over clear", mf_irq, 1);
    set_exp(200, 0);
    sweep("R2 multiframe C");
    check("R8 rai after single Y=0", rai, 1);
    rd(8'h07, d);

    mf(37, 1, 1);
    mf(142, 0, 1);
    mf(77, 0, 0);

    rd(8'h2F, d); check("R9 unmapped 0x2F", d, 0);
    rd(8'h40, d); check("R9 unmapped 0x40", d, 0);
    rd(8'h00, d); check("R9 unmapped 0x00", d, 0);
    rd(8'h35, held);
    check("R9 read 0x35", held, exp_reg[5]);
    repeat (3) @(negedge clk);
    check("R9 data holds without rd_en", rd_data, held);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule